// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block watches the acknowledge and fault lines of a parallel printer interface and turns their edges into an interrupt. Both lines are asynchronous to the core clock. Each line passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with a registered copy of the previous sample. The acknowledge edge that counts is chosen by software, rising or falling. The fault edge that counts is always falling.

Software sees one 8-bit interrupt control register, written through `wr_en`/`wr_data` and always visible on `rd_data`. Its fields are:

- Bits 2..0: the interrupt priority level, driven out on `irq_level`.
- Bit 3: the enable.
- Bit 4: the acknowledge polarity.
- Bit 5: a sticky acknowledge flag.
- Bit 6: a sticky fault flag.
- Bit 7: a read-only summary bit, the OR of the two flags.

A flag clears when software writes 1 to its bit. The acknowledge flag also clears when the enable is 0. The request `irq_req` is raised while the summary bit and the enable are both 1.

The external reset is asynchronous and active-low. Inside the block, its release is synchronised to the clock.

Top module: `prn_irq_ctrl`

## Requirements
- R1: While reset is active and after its release, `rd_data` reads 0x00, `irq_req` is 0 and `irq_level` is 0.
- R2: A write loads bits 2..0 (level), bit 3 (enable) and bit 4 (polarity) from `wr_data`. These appear on `rd_data` in the cycle after the write edge. `irq_level` always equals bits 2..0.
- R3: With bit 4 = 1, a falling edge of `ack_in` sets bit 5. With bit 4 = 0, a rising edge sets it. The opposite edge has no effect. The flag shows after the third rising clock edge that follows the input change.
- R4: A falling edge of `fault_in` sets bit 6, with the same three-edge latency. A rising edge has no effect.
- R5: Writing 1 to bit 5 or bit 6 clears that flag. Writing 0 to either bit leaves it unchanged.
- R6: Bit 5 is held at 0 whenever the stored enable (bit 3) is 0. A write that clears the enable also clears bit 5 at the same edge. Acknowledge edges that arrive while the enable is 0 are lost.
- R7: Bit 7 reads as bit 5 OR bit 6. Writes to bit 7 have no effect.
- R8: `irq_req` is 1 exactly when bit 7 and bit 3 are both 1.
- R9: When a flag's event and a write-1 clear of that flag fall in the same cycle, the flag ends up 1.
- R10: The fault flag is captured regardless of the enable. While the enable is 0 it shows in bits 6 and 7, but `irq_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_in | input | 1 | Printer acknowledge line, asynchronous |
| fault_in | input | 1 | Printer fault line, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt priority level |

## Verification
The assertions treat `wr_en` and `wr_data` as synchronous to `clk`. They also assume each printer line stays stable long enough to be seen by the synchroniser, so that every change produces exactly one edge event. The bench meets both assumptions. It drives all inputs one time unit after a rising edge. It holds each line level for at least three clock edges before the next change or check. It keeps both lines low through reset, so the synchroniser never sees a spurious edge at release.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;
  localparam int REG_W    = 8;
  localparam int LVL_W    = 3;
  localparam int LVL_LSB  = 0;
  localparam int EN_BIT   = 3;
  localparam int POL_BIT  = 4;
  localparam int ACKF_BIT = 5;
  localparam int FLTF_BIT = 6;
  localparam int SUM_BIT  = 7;
  localparam int N_LINES  = 2;
  localparam int LINE_ACK = 0;
  localparam int LINE_FLT = 1;

  typedef struct packed {
    logic             pol;
    logic             en;
    logic [LVL_W-1:0] lvl;
  } cfg_t;
endpackage

// File: rtl/prn_rst_sync.sv
module prn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ns = sh_q[STAGES-1];
endmodule

// File: rtl/prn_sync_edge.sv
module prn_sync_edge #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] ev
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              prev_q;
    logic              lvl;
    logic              rise;
    logic              fall;

    assign lvl = sh_q[STAGES-1];

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= sh_d;
        prev_q <= lvl;
      end
    end

    assign rise  = lvl & ~prev_q;
    assign fall  = ~lvl & prev_q;
    assign ev[i] = fall_sel[i] ? fall : rise;

    // R3: an event implies the synchronised level moved since last sample
    a_r3_event_is_change: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |-> (lvl != prev_q));
  end
endmodule

// File: rtl/prn_irq_regs.sv
module prn_irq_regs
  import prn_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_ev,
  input  logic             fault_ev,
  output cfg_t             cfg,
  output logic             ack_flag,
  output logic             fault_flag
);
  cfg_t cfg_q, cfg_d;
  logic ack_q, ack_d;
  logic flt_q, flt_d;
  logic ack_clr, flt_clr;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.lvl = wr_data[LVL_LSB +: LVL_W];
      cfg_d.en  = wr_data[EN_BIT];
      cfg_d.pol = wr_data[POL_BIT];
    end
    ack_clr = wr_en & wr_data[ACKF_BIT];
    flt_clr = wr_en & wr_data[FLTF_BIT];
    ack_d   = cfg_d.en & (ack_ev | (ack_q & ~ack_clr));
    flt_d   = fault_ev | (flt_q & ~flt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ack_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ack_q <= ack_d;
      flt_q <= flt_d;
    end
  end

  assign cfg        = cfg_q;
  assign ack_flag   = ack_q;
  assign fault_flag = flt_q;

  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q.lvl == $past(wr_data[LVL_LSB +: LVL_W]) &&
               cfg_q.en  == $past(wr_data[EN_BIT]) &&
               cfg_q.pol == $past(wr_data[POL_BIT])));
  a_r6_ack_low_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !ack_q);
  a_r9_ack_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && cfg_d.en) |=> ack_q);
  a_r4_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> flt_q);
  a_r5_fault_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLTF_BIT] && !fault_ev) |=> !flt_q);
  a_r5_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_data[FLTF_BIT]) && !fault_ev) |=> $stable(flt_q));
endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in,
  input  logic             fault_in,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic               rst_ns;
  logic [N_LINES-1:0] lines;
  logic [N_LINES-1:0] fall_sel;
  logic [N_LINES-1:0] ev;
  cfg_t               cfg;
  logic               ack_flag;
  logic               fault_flag;
  logic               summary;

  prn_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    lines              = '0;
    lines[LINE_ACK]    = ack_in;
    lines[LINE_FLT]    = fault_in;
    fall_sel           = '0;
    fall_sel[LINE_ACK] = cfg.pol;
    fall_sel[LINE_FLT] = 1'b1;
  end

  prn_sync_edge #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_ns),
    .din      (lines),
    .fall_sel (fall_sel),
    .ev       (ev)
  );

  prn_irq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ack_ev     (ev[LINE_ACK]),
    .fault_ev   (ev[LINE_FLT]),
    .cfg        (cfg),
    .ack_flag   (ack_flag),
    .fault_flag (fault_flag)
  );

  assign summary = ack_flag | fault_flag;

  always_comb begin
    rd_data                         = '0;
    rd_data[LVL_LSB +: LVL_W]       = cfg.lvl;
    rd_data[EN_BIT]                 = cfg.en;
    rd_data[POL_BIT]                = cfg.pol;
    rd_data[ACKF_BIT]               = ack_flag;
    rd_data[FLTF_BIT]               = fault_flag;
    rd_data[SUM_BIT]                = summary;
  end

  assign irq_req   = summary & cfg.en;
  assign irq_level = cfg.lvl;

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_req |-> rd_data[EN_BIT]);
  a_r6_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !wr_data[EN_BIT]) |=> !irq_req);
  a_r7_sum_tracks_flags: assert property (@(posedge clk) disable iff (!rst_ns)
    ev[LINE_FLT] |=> rd_data[SUM_BIT]);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_ns |-> (!irq_req && irq_level == '0));
endmodule

// File: tb/prn_irq_ctrl_test.sv
`timescale 1ns/1ps
module prn_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ack_in, fault_in, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_req;
  logic [2:0] irq_level;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  prn_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .fault_in(fault_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    step();
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cfg;
    logic       lvl;
    logic       exp;
    rst_n = 1'b0; ack_in = 1'b0; fault_in = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    #12;
    // R1: in reset
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 irq", irq_req, 0);
    rst_n = 1'b1;
    step(5);
    chk("R1 rd after release", rd_data, 8'h00);
    chk("R1 level", irq_level, 0);

    // R2/R7: sweep every write value with flags clear
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R2 R7 readback", rd_data, {3'b000, v[4:0]});
      chk("R2 level out", irq_level, v[2:0]);
      chk("R8 irq idle", irq_req, 0);
    end

    // R3: both polarities, both edge directions
    lvl = 1'b0;
    for (int pol = 0; pol < 2; pol++) begin
      cfg = 8'h08 | (pol[0] ? 8'h10 : 8'h00) | 8'h05;
      wr(cfg | 8'h60);
      for (int t = 0; t < 4; t++) begin
        lvl = ~lvl;
        ack_in = lvl;
        step(2);
        chk("R3 no early flag", rd_data[5], 0);
        step(1);
        exp = pol[0] ? ~lvl : lvl;
        chk("R3 ack edge", rd_data[5], exp);
        chk("R7 summary", rd_data[7], exp);
        chk("R8 irq", irq_req, exp);
        // R5: write 0 keeps
        wr(cfg);
        chk("R5 ack hold", rd_data[5], exp);
        wr(cfg | 8'h20);
        chk("R5 ack w1c", rd_data[5], 0);
      end
    end
    ack_in = 1'b0;
    step(4);

    // R9: ack edge and clear in same cycle (rising polarity)
    wr(8'h08 | 8'h60);
    ack_in = 1'b1;
    step(2);
    wr(8'h08 | 8'h20);
    chk("R9 ack set wins", rd_data[5], 1);

    // R6: disabling clears ack flag and irq
    wr(8'h00);
    chk("R6 ack cleared by disable", rd_data[5], 0);
    chk("R6 irq low", irq_req, 0);
    ack_in = 1'b0;
    step(3);
    ack_in = 1'b1;
    step(3);
    wr(8'h08);
    chk("R6 edge while disabled lost", rd_data[5], 0);
    wr(8'h00);

    // R4/R10: fault while disabled
    fault_in = 1'b1;
    step(3);
    chk("R4 rising ignored", rd_data[6], 0);
    fault_in = 1'b0;
    step(2);
    chk("R4 no early flag", rd_data[6], 0);
    step(1);
    chk("R4 fault falling", rd_data[6], 1);
    chk("R10 summary", rd_data[7], 1);
    chk("R10 irq gated", irq_req, 0);
    wr(8'h0B);
    chk("R8 irq enabled", irq_req, 1);
    chk("R8 level", irq_level, 3);
    wr(8'h80);
    chk("R7 bit7 write ignored", rd_data, 8'hC0);
    wr(8'h48);
    chk("R5 fault w1c", rd_data, 8'h08);
    chk("R8 irq dropped", irq_req, 0);

    // R9: fault edge with clear same cycle
    fault_in = 1'b1;
    step(3);
    fault_in = 1'b0;
    step(2);
    wr(8'h48);
    chk("R9 fault set wins", rd_data[6], 1);
    chk("R8 irq", irq_req, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule